// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a 12-bit configuration word and a starting column into the stream of column addresses that a single read or write burst visits, one address per clock. It decodes the burst length (1, 2, 4, 8 or a page that runs until stopped), the ordering (linear wrap within the burst block, or XOR interleave), the read latency field and a mode that shortens every write burst to one beat while reads keep their programmed length.

A command front end pulses `start` with the starting column and the direction. One cycle later the first address appears with `col_valid` high, and the sequencer then steps once per clock. `last_beat` marks the final address of a bounded burst. A `stop` pulse ends any burst at once. A new `start` during a burst replaces it. Configuration words that use reserved codes raise `cfg_err`, and starts are refused while the flag is high.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and after it until the first accepted start, `col_valid` and `last_beat` are 0.
- R2: Length field bits 2:0 give 000 = 1, 001 = 2, 010 = 4, 011 = 8 beats. `last_beat` is 1 only on the final beat, and `col_valid` is 0 in the cycle after it.
- R3: With bit 3 = 0, beat k has column bits above log2(BL) equal to the start column, and its low log2(BL) bits equal (start low bits + k) mod BL.
- R4: With bit 3 = 1, beat k equals the start column with its low log2(BL) bits XORed with k.
- R5: Length code 111 with bit 3 = 0 gives a page burst: beat k is (start + k) mod 512, `last_beat` stays 0, and the burst runs until stopped.
- R6: With bit 9 = 1, a start with `is_write` = 1 yields exactly one beat. A start with `is_write` = 0 keeps the programmed length.
- R7: `stop` high with `start` low makes `col_valid` 0 in the next cycle.
- R8: Latency field bits 6:4 = 010 gives `cas_lat` = 2, and 011 gives 3. Any other value sets `cfg_err`.
- R9: `cfg_err` is 1 for length codes 100, 101 and 110, for 111 with bit 3 = 1, and for any 1 in bits 8:7 or 11:10. A start while `cfg_err` = 1 leaves `col_valid` at 0.
- R10: A start during a burst abandons it, and the next cycle shows the new start column as beat 0.
- R11: The first address equals `start_col` and appears in the cycle after the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_word | input | 12 | Configuration word |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Starting column |
| stop | input | 1 | End the current burst |
| is_write | input | 1 | Direction of the burst being started |
| col_addr | output | 9 | Current column address |
| col_valid | output | 1 | `col_addr` holds a beat |
| last_beat | output | 1 | Current beat is the final one of a bounded burst |
| cfg_err | output | 1 | Configuration word uses a reserved code |
| cas_lat | output | 2 | Decoded read latency (0 when invalid) |

## Verification
The properties assume that `mode_word` and `is_write` stay unchanged from a start until its burst ends, because the page-step property reads the mode from the ports rather than from the latched copy. They also assume that `start` is not held low in the cycle reset is released only to be raised at that same edge. The stimulus changes the mode word and direction only at the start of a burst or while idle, and it drives every input on the falling clock edge.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int MODE_W = 12;

    typedef struct packed {
        logic       err;
        logic [1:0] len_log;
        logic       full_page;
        logic       interleave;
        logic       single_wr;
        logic [1:0] cas;
    } bcs_cfg_t;

endpackage

// File: rtl/bcs_mode_dec.sv
module bcs_mode_dec
    import bcs_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output bcs_cfg_t          cfg
);
    logic [2:0] len_code;
    logic [2:0] lat_code;
    logic       len_bad;
    logic       lat_bad;
    logic       pad_bad;

    always_comb begin
        len_code       = mode_word[2:0];
        lat_code       = mode_word[6:4];
        cfg            = '0;
        cfg.interleave = mode_word[3];
        cfg.single_wr  = mode_word[9];
        len_bad        = 1'b0;
        unique case (len_code)
            3'b000:  cfg.len_log = 2'd0;
            3'b001:  cfg.len_log = 2'd1;
            3'b010:  cfg.len_log = 2'd2;
            3'b011:  cfg.len_log = 2'd3;
            3'b111: begin
                cfg.full_page = 1'b1;
                len_bad       = mode_word[3];
            end
            default: len_bad = 1'b1;
        endcase
        lat_bad = 1'b0;
        unique case (lat_code)
            3'b010:  cfg.cas = 2'd2;
            3'b011:  cfg.cas = 2'd3;
            default: lat_bad = 1'b1;
        endcase
        pad_bad = |{mode_word[11:10], mode_word[8:7]};
        cfg.err = len_bad | lat_bad | pad_bad;
        if (cfg.err) cfg.cas = 2'd0;
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic             active,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [1:0]       len_log,
    input  logic             interleave,
    input  logic             full_page,
    output logic [COL_W-1:0] addr,
    output logic             last
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        mask = (COL_W'(1) << len_log) - COL_W'(1);
        sum  = base + beat;
        if (full_page)
            addr = sum;
        else if (interleave)
            addr = base ^ (beat & mask);
        else
            addr = (base & ~mask) | (sum & mask);
        last = active && !full_page && (beat == mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    input  logic              is_write,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              last_beat,
    output logic              cfg_err,
    output logic [1:0]        cas_lat
);
    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [1:0]       len_log;
        logic             interleave;
        logic             full_page;
    } seq_state_t;

    bcs_cfg_t   cfg;
    seq_state_t st_d, st_q;
    logic       last_w;
    logic       one_beat;

    bcs_mode_dec i_dec (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    bcs_addr_gen #(.COL_W(COL_W)) i_gen (
        .active     (st_q.active),
        .base       (st_q.base),
        .beat       (st_q.beat),
        .len_log    (st_q.len_log),
        .interleave (st_q.interleave),
        .full_page  (st_q.full_page),
        .addr       (col_addr),
        .last       (last_w)
    );

    always_comb begin
        st_d     = st_q;
        one_beat = cfg.single_wr && is_write;
        if (start && !cfg.err) begin
            st_d.active     = 1'b1;
            st_d.base       = start_col;
            st_d.beat       = '0;
            st_d.len_log    = one_beat ? 2'd0 : cfg.len_log;
            st_d.interleave = cfg.interleave;
            st_d.full_page  = cfg.full_page && !one_beat;
        end else if (stop || last_w) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            st_d.beat = st_q.beat + COL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_valid = st_q.active;
    assign last_beat = last_w;
    assign cfg_err   = cfg.err;
    assign cas_lat   = cfg.cas;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_word,
    input logic              start,
    input logic [COL_W-1:0]  start_col,
    input logic              stop,
    input logic              is_write,
    input logic [COL_W-1:0]  col_addr,
    input logic              col_valid,
    input logic              last_beat,
    input logic              cfg_err,
    input logic [1:0]        cas_lat
);
    logic page_mode;
    assign page_mode = (mode_word[2:0] == 3'b111) && !mode_word[3] &&
                       !(mode_word[9] && is_write) && !cfg_err;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !col_valid && !last_beat);

    assert_last_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid);

    assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat && !start |=> !col_valid);

    assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && page_mode && !start && !stop |=>
            col_valid && !last_beat && col_addr == $past(col_addr) + COL_W'(1));

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !start |=> !col_valid);

    assert_latency_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_err |-> (cas_lat == 2'd2 || cas_lat == 2'd3));

    assert_refuse_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && cfg_err && !col_valid |=> !col_valid);

    assert_first_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start && !cfg_err |=> col_valid && col_addr == $past(start_col));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) i_chk (.*);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    localparam int WATCHDOG   = 20000;

    // {mode word, start column, write, expected beats}
    localparam logic [25:0] VEC [NVEC] = '{
        {12'h020, 9'h05A, 1'b0, 4'd1},
        {12'h021, 9'h0FF, 1'b0, 4'd2},
        {12'h022, 9'h1F6, 1'b0, 4'd4},
        {12'h023, 9'h135, 1'b0, 4'd8},
        {12'h02B, 9'h135, 1'b0, 4'd8},
        {12'h02A, 9'h007, 1'b0, 4'd4},
        {12'h029, 9'h100, 1'b0, 4'd2},
        {12'h233, 9'h044, 1'b1, 4'd1},
        {12'h233, 9'h044, 1'b0, 4'd8},
        {12'h022, 9'h0AB, 1'b1, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mode_word = 12'h020;
    logic        start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        stop = 1'b0;
    logic        is_write = 1'b0;
    logic [8:0]  col_addr;
    logic        col_valid;
    logic        last_beat;
    logic        cfg_err;
    logic [1:0]  cas_lat;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk, .rst_n, .mode_word, .start, .start_col, .stop, .is_write,
        .col_addr, .col_valid, .last_beat, .cfg_err, .cas_lat
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(int base, int k, int bl, bit ilv);
        int blk, off;
        blk = base - (base % bl);
        off = base % bl;
        if (ilv) return blk + (off ^ k);
        return blk + ((off + k) % bl);
    endfunction

    task automatic kick(input logic [11:0] m, input logic [8:0] c, input logic w);
        mode_word = m;
        start_col = c;
        is_write  = w;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", col_valid, 0);
        check("R1 last in reset", last_beat, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", col_valid, 0);

        // table walk: R2 R3 R4 R6 R8 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [11:0] m;
            logic [8:0]  c;
            logic        w;
            int          nb, bl;
            {m, c, w, nb} = {VEC[v][25:14], VEC[v][13:5], VEC[v][4], 32'(VEC[v][3:0])};
            bl = 1 << m[1:0];
            kick(m, c, w);
            check("R8 latency", cas_lat, int'(m[6:4]));
            check("R8 no error", cfg_err, 0);
            for (int k = 0; k < nb; k++) begin
                check("R11 valid", col_valid, 1);
                check(m[3] ? "R4 interleave addr" : "R3 sequential addr",
                      col_addr, exp_addr(c, k, bl, m[3]));
                check("R2 last flag", last_beat, (k == nb - 1) ? 1 : 0);
                @(negedge clk);
            end
            check("R6 R2 burst ended", col_valid, 0);
        end

        // R5 page burst with wrap, then stop (R7)
        kick(12'h027, 9'h1FE, 1'b0);
        for (int k = 0; k < 6; k++) begin
            check("R5 page addr", col_addr, (9'h1FE + k) % 512);
            check("R5 page no last", last_beat, 0);
            @(negedge clk);
        end
        check("R5 page still running", col_valid, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R7 stop ends page", col_valid, 0);

        // R7 early stop of a bounded burst
        kick(12'h023, 9'h010, 1'b0);
        @(negedge clk);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R7 early stop", col_valid, 0);

        // R10 restart mid-burst
        kick(12'h023, 9'h000, 1'b0);
        @(negedge clk);
        kick(12'h023, 9'h0F3, 1'b0);
        check("R10 restart addr", col_addr, 9'h0F3);
        check("R10 restart valid", col_valid, 1);
        @(negedge clk);
        check("R10 restart step", col_addr, 9'h0F4);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;

        // R9 reserved codes refuse start; R8 latency reserved
        begin
            logic [11:0] badm [6] = '{12'h02F, 12'h024, 12'h0A2, 12'h422, 12'h012, 12'h026};
            for (int i = 0; i < 6; i++) begin
                kick(badm[i], 9'h033, 1'b0);
                check("R9 R8 error flag", cfg_err, 1);
                check("R9 start refused", col_valid, 0);
                check("R8 latency zero on error", cas_lat, 0);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule